// File: doc/BRIEF.md
# Group Dimming and Blinking LED Modulator

This block produces one shared gate that modulates several LED channels together. Each channel also has its own fast brightness PWM. A 2-bit select field per channel picks one of four behaviours for that channel's drive bit:

- forced off
- forced on
- the channel's own PWM alone
- the channel's own PWM ANDed with the shared gate

The shared gate has two modes. In dimming mode, a slow fixed-rate PWM acts as a global dimmer. In blinking mode, a programmable period and an on/off ratio give a common blink pattern.

Timing comes from three tick enables that a prescaler outside the block supplies:

- a fast tick for the per-channel PWM (about 6.25 kHz × 256)
- a dimming tick for the group PWM (about 190 Hz × 256)
- a blink sub-step tick (24 Hz × 256)

A group cycle always has 256 phase steps. In blinking mode each phase step lasts (period value + 1) blink ticks. The blink period therefore runs from about 1/24 s up to about 10.7 s. The number of duty bits that count depends on the mode and on the period value. The group duty, the period value and the mode are captured only when a new group cycle starts.

Top module: `led_group_modulator`

## Requirements
- R1: After reset the captured group duty is FFh and the captured mode is dimming. The first group cycle therefore holds the gate high for 240 of its 256 dimming steps.
- R2: In dimming mode the phase advances once per dimming tick through 256 steps. The gate is high while the phase is below the duty with its low 4 bits forced to zero. The low 4 bits have no effect.
- R3: In dimming mode the period value and the blink tick have no effect on the gate.
- R4: In blinking mode (mode bit 1) the phase advances once every (P+1) blink ticks, where P is the captured period value. A group cycle lasts 256·(P+1) blink ticks, and the gate is high from the start of the cycle.
- R5: In blinking mode with P ≤ 3, duty bits [1:0] are ignored. The most high time per cycle is 252 phase steps.
- R6: In blinking mode with P ≥ 4, all 8 duty bits count. A duty of FFh gives 255 high phase steps.
- R7: A captured duty of 00h holds the gate low for the whole cycle, in either mode.
- R8: A change to the duty, the period or the mode in the middle of a cycle does not alter that cycle. It applies from the next cycle start.
- R9: The per-channel PWM is an 8-bit counter that advances on the fast tick. A channel's own PWM is on while the counter is below that channel's duty.
- R10: Select codes per channel act as follows:
  - 00 drives the channel low.
  - 01 drives it high.
  - 10 passes the channel's own PWM.
  - 11 passes the channel's own PWM ANDed with the group gate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fast_tick | input | 1 | Step enable for the per-channel PWM counter |
| dim_tick | input | 1 | Phase step enable in dimming mode |
| blink_tick | input | 1 | Sub-step enable in blinking mode |
| grp_duty | input | 8 | Group duty value |
| grp_period | input | 8 | Blink period value P |
| blink_mode | input | 1 | 0 = dimming, 1 = blinking |
| ind_duty | input | 32 | Per-channel duty values, channel i at bits [8i+7:8i] |
| out_sel | input | 8 | Per-channel select codes, channel i at bits [2i+1:2i] |
| ch_drive | output | 4 | Channel drive bits |

## Verification
The bench builds the block with its default parameters: four channels, 8-bit duty and period, and a fast-blink limit of 3. It drives every tick each clock, so a dimming cycle takes 256 clocks and a blink cycle takes 256·(P+1) clocks. This makes it practical to count the exact number of gate-high clocks over whole cycles. Blink periods stay small, but they include both sides of the 3/4 resolution threshold. Mid-cycle changes to duty and mode, zero duty, and every select code are checked directly.

// File: rtl/lgm_pkg.sv
// Shared types for the group LED modulator.
// Assumes: select codes are 2 bits wide and their encoding is fixed.
package lgm_pkg;
    typedef enum logic [1:0] {
        SEL_OFF = 2'b00,
        SEL_ON  = 2'b01,
        SEL_IND = 2'b10,
        SEL_GRP = 2'b11
    } sel_e;
endpackage

// File: rtl/grp_timebase.sv
// Group phase generator with shadow capture of the settings.
// Dimming mode: the phase steps once per dim_tick.
// Blinking mode: the phase steps once every (period+1) blink ticks.
// Duty, period and mode are captured only when the phase wraps.
// Assumes: ticks are single-cycle enables from an outside prescaler.
module grp_timebase #(
    parameter int DUTY_W = 8,
    parameter int PER_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dim_tick,
    input  logic              blink_tick,
    input  logic [DUTY_W-1:0] grp_duty,
    input  logic [PER_W-1:0]  grp_period,
    input  logic              blink_mode,
    output logic [DUTY_W-1:0] phase,
    output logic [DUTY_W-1:0] duty_q,
    output logic [PER_W-1:0]  period_q,
    output logic              mode_q,
    output logic              step,
    output logic              wrap
);
    logic [PER_W-1:0]  sub_q;
    logic [DUTY_W-1:0] phase_q;

    // Decide whether the phase advances this cycle.
    always_comb begin
        step = mode_q ? (blink_tick && (sub_q == period_q)) : dim_tick;
        wrap = step && (phase_q == '1);
    end

    // Advance the sub-step and phase counters; capture the shadows on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_q    <= '0;
            phase_q  <= '0;
            duty_q   <= '1;
            period_q <= '0;
            mode_q   <= 1'b0;
        end else begin
            if (blink_tick)
                sub_q <= (sub_q == period_q) ? '0 : sub_q + 1'b1;
            if (step)
                phase_q <= phase_q + 1'b1;
            if (wrap) begin
                duty_q   <= grp_duty;
                period_q <= grp_period;
                mode_q   <= blink_mode;
                sub_q    <= '0;
            end
        end
    end

    assign phase = phase_q;
endmodule

// File: rtl/grp_gate_cmp.sv
// Group gate comparator.
// Masks the captured duty to the resolution of the active mode, then
// compares it with the phase.
// Assumes: DIM_BITS and FAST_BITS are no larger than DUTY_W.
module grp_gate_cmp #(
    parameter int DUTY_W    = 8,
    parameter int PER_W     = 8,
    parameter int DIM_BITS  = 4,
    parameter int FAST_BITS = 6,
    parameter int FAST_MAX  = 3
) (
    input  logic [DUTY_W-1:0] phase,
    input  logic [DUTY_W-1:0] duty_q,
    input  logic [PER_W-1:0]  period_q,
    input  logic              mode_q,
    output logic              gate
);
    localparam logic [DUTY_W-1:0] DIM_MASK =
        {{DIM_BITS{1'b1}}, {(DUTY_W-DIM_BITS){1'b0}}};
    localparam logic [DUTY_W-1:0] FAST_MASK =
        {{FAST_BITS{1'b1}}, {(DUTY_W-FAST_BITS){1'b0}}};
    localparam logic [PER_W-1:0] FAST_LIM = PER_W'(FAST_MAX);

    logic [DUTY_W-1:0] eff_duty;

    // Pick the duty resolution, then compare it with the phase.
    always_comb begin
        if (!mode_q)
            eff_duty = duty_q & DIM_MASK;
        else if (period_q <= FAST_LIM)
            eff_duty = duty_q & FAST_MASK;
        else
            eff_duty = duty_q;
        gate = (phase < eff_duty);
    end
endmodule

// File: rtl/ind_pwm_bank.sv
// Per-channel PWM.
// One shared counter advances on fast_tick; each channel compares the
// counter with its own duty.
// Assumes: ind_duty is packed with channel i at bits [i*DUTY_W +: DUTY_W].
module ind_pwm_bank #(
    parameter int NUM_CH = 4,
    parameter int DUTY_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fast_tick,
    input  logic [NUM_CH*DUTY_W-1:0] ind_duty,
    output logic [NUM_CH-1:0]        ind_on
);
    logic [DUTY_W-1:0] cnt_q;

    // Shared free-running counter, gated by the fast tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (fast_tick)
            cnt_q <= cnt_q + 1'b1;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_cmp
        // Channel is on while the counter is below its duty.
        always_comb ind_on[i] = (cnt_q < ind_duty[i*DUTY_W +: DUTY_W]);
    end
endmodule

// File: rtl/chan_select.sv
// Per-channel output select.
// Chooses off, on, the channel's own PWM, or that PWM gated by the group signal.
// Assumes: out_sel is packed with channel i at bits [2i+1:2i].
module chan_select
    import lgm_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic [NUM_CH*2-1:0] out_sel,
    input  logic [NUM_CH-1:0]   ind_on,
    input  logic                grp_gate,
    output logic [NUM_CH-1:0]   ch_drive
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_mux
        sel_e sel;
        // Decode this channel's select field and drive its output.
        always_comb begin
            sel = sel_e'(out_sel[i*2 +: 2]);
            case (sel)
                SEL_OFF: ch_drive[i] = 1'b0;
                SEL_ON:  ch_drive[i] = 1'b1;
                SEL_IND: ch_drive[i] = ind_on[i];
                default: ch_drive[i] = ind_on[i] & grp_gate;
            endcase
        end
    end
endmodule

// File: rtl/led_group_modulator.sv
// Top level of the group dimming and blinking LED modulator.
// Connects the group timebase, the gate comparator, the per-channel PWM
// bank and the output select.
// Assumes: all tick enables are synchronous to clk.
module led_group_modulator #(
    parameter int NUM_CH   = 4,
    parameter int DUTY_W   = 8,
    parameter int PER_W    = 8,
    parameter int FAST_MAX = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fast_tick,
    input  logic                     dim_tick,
    input  logic                     blink_tick,
    input  logic [DUTY_W-1:0]        grp_duty,
    input  logic [PER_W-1:0]         grp_period,
    input  logic                     blink_mode,
    input  logic [NUM_CH*DUTY_W-1:0] ind_duty,
    input  logic [NUM_CH*2-1:0]      out_sel,
    output logic [NUM_CH-1:0]        ch_drive
);
    logic [DUTY_W-1:0] grp_phase;
    logic [DUTY_W-1:0] duty_q;
    logic [PER_W-1:0]  period_q;
    logic              mode_q;
    logic              grp_step;
    logic              grp_wrap;
    logic              grp_gate;
    logic [NUM_CH-1:0] ind_on;

    grp_timebase #(.DUTY_W(DUTY_W), .PER_W(PER_W)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .dim_tick  (dim_tick),
        .blink_tick(blink_tick),
        .grp_duty  (grp_duty),
        .grp_period(grp_period),
        .blink_mode(blink_mode),
        .phase     (grp_phase),
        .duty_q    (duty_q),
        .period_q  (period_q),
        .mode_q    (mode_q),
        .step      (grp_step),
        .wrap      (grp_wrap)
    );

    grp_gate_cmp #(
        .DUTY_W   (DUTY_W),
        .PER_W    (PER_W),
        .DIM_BITS (DUTY_W/2),
        .FAST_BITS(DUTY_W-2),
        .FAST_MAX (FAST_MAX)
    ) u_cmp (
        .phase   (grp_phase),
        .duty_q  (duty_q),
        .period_q(period_q),
        .mode_q  (mode_q),
        .gate    (grp_gate)
    );

    ind_pwm_bank #(.NUM_CH(NUM_CH), .DUTY_W(DUTY_W)) u_ind (
        .clk      (clk),
        .rst_n    (rst_n),
        .fast_tick(fast_tick),
        .ind_duty (ind_duty),
        .ind_on   (ind_on)
    );

    chan_select #(.NUM_CH(NUM_CH)) u_sel (
        .out_sel (out_sel),
        .ind_on  (ind_on),
        .grp_gate(grp_gate),
        .ch_drive(ch_drive)
    );
endmodule

// File: rtl/lgm_chk.sv
// Assertion checker for led_group_modulator, attached with bind.
// Observes the ports and the signals passed between the submodules.
module lgm_chk #(
    parameter int NUM_CH = 4,
    parameter int DUTY_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_CH*2-1:0] out_sel,
    input logic [NUM_CH-1:0]   ch_drive,
    input logic [NUM_CH-1:0]   ind_on,
    input logic                grp_gate,
    input logic [DUTY_W-1:0]   grp_phase,
    input logic [DUTY_W-1:0]   duty_q,
    input logic                mode_q,
    input logic                grp_wrap
);
    localparam logic [DUTY_W-1:0] DIM_TOP =
        {{(DUTY_W/2){1'b1}}, {(DUTY_W-DUTY_W/2){1'b0}}};

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        // R10
        off_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_sel[i*2 +: 2] == 2'b00) |-> !ch_drive[i]);
        // R10
        on_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_sel[i*2 +: 2] == 2'b01) |-> ch_drive[i]);
        // R10
        ind_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_sel[i*2 +: 2] == 2'b10) |-> (ch_drive[i] == ind_on[i]));
    end

    // R7
    zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_q == '0) |-> !grp_gate);

    // R8
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_wrap |=> ($stable(duty_q) && $stable(mode_q)));

    // R2
    dim_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && grp_phase >= DIM_TOP) |-> !grp_gate);

    // R4
    phase_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grp_wrap |=> (grp_phase == '0));
endmodule

bind led_group_modulator lgm_chk #(.NUM_CH(NUM_CH), .DUTY_W(DUTY_W)) u_lgm_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .out_sel  (out_sel),
    .ch_drive (ch_drive),
    .ind_on   (ind_on),
    .grp_gate (grp_gate),
    .grp_phase(grp_phase),
    .duty_q   (duty_q),
    .mode_q   (mode_q),
    .grp_wrap (grp_wrap)
);

// File: tb/test_led_group_modulator.sv
`timescale 1ns/1ps
module test_led_group_modulator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fast_tick = 1'b0;
    logic        dim_tick = 1'b1;
    logic        blink_tick = 1'b1;
    logic [7:0]  grp_duty = 8'hFF;
    logic [7:0]  grp_period = 8'h00;
    logic        blink_mode = 1'b0;
    logic [31:0] ind_duty = {4{8'h80}};
    logic [7:0]  out_sel = 8'b00_01_10_11;
    logic [3:0]  ch_drive;

    int n_chk = 0;
    int n_bad = 0;
    int hi [4];

    led_group_modulator i_led_group_modulator (
        .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .dim_tick(dim_tick),
        .blink_tick(blink_tick), .grp_duty(grp_duty), .grp_period(grp_period),
        .blink_mode(blink_mode), .ind_duty(ind_duty), .out_sel(out_sel),
        .ch_drive(ch_drive)
    );

    always #4 clk = ~clk;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected gate-high clocks over one cycle (all ticks every clock).
    function automatic int exp_hi(bit mode, logic [7:0] d, logic [7:0] p);
        if (!mode) return int'(d & 8'hF0);
        if (p <= 8'd3) return int'(d & 8'hFC) * (int'(p) + 1);
        return int'(d) * (int'(p) + 1);
    endfunction

    function automatic int cyc_len(bit mode, logic [7:0] p);
        return mode ? 256 * (int'(p) + 1) : 256;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Sample n clocks at negedges, counting high clocks per channel.
    task automatic measure(int n);
        for (int c = 0; c < 4; c++) hi[c] = 0;
        repeat (n) begin
            for (int c = 0; c < 4; c++) if (ch_drive[c]) hi[c]++;
            @(negedge clk);
        end
    endtask

    // Reset, run the reset-default cycle, then measure one cycle of the new setting.
    task automatic run_case(string req, bit mode, logic [7:0] d, logic [7:0] p);
        blink_mode = mode; grp_duty = d; grp_period = p;
        do_reset();
        measure(256);
        chk("R1 reset cycle", hi[0], 240);
        measure(cyc_len(mode, p));
        chk(req, hi[0], exp_hi(mode, d, p));
        chk("R4 next cycle starts", int'(ch_drive[0]), int'(exp_hi(mode, d, p) > 0));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk("watchdog", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        do_reset();
        // R1 R10: after reset the gate is high at phase 0; check all four select codes.
        chk("R1 R10 reset drive", int'(ch_drive), 4'b0111);

        run_case("R2 dim FF", 1'b0, 8'hFF, 8'h55);
        run_case("R2 dim low nibble ignored", 1'b0, 8'h8F, 8'h00);
        run_case("R3 dim period ignored", 1'b0, 8'h8F, 8'hFF);
        run_case("R7 dim zero", 1'b0, 8'h00, 8'h10);
        run_case("R5 blink P3 max", 1'b1, 8'hFF, 8'd3);
        run_case("R6 blink P4 max", 1'b1, 8'hFF, 8'd4);
        run_case("R5 blink low bits ignored", 1'b1, 8'h03, 8'd0);
        run_case("R6 blink duty 1", 1'b1, 8'h01, 8'd5);
        run_case("R7 blink zero", 1'b1, 8'h00, 8'd2);
        run_case("R4 blink P1", 1'b1, 8'h80, 8'd1);

        // R3: in dimming mode the blink tick has no effect.
        blink_tick = 1'b0;
        run_case("R3 dim without blink tick", 1'b0, 8'h55, 8'd7);
        blink_tick = 1'b1;

        // R8: changes made mid-cycle wait for the next cycle start.
        blink_mode = 1'b0; grp_duty = 8'h40; grp_period = 8'd0;
        do_reset();
        measure(256);
        measure(10);
        chk("R8 first part", hi[0], 10);
        grp_duty = 8'hC0; blink_mode = 1'b1; grp_period = 8'd2;
        measure(246);
        chk("R8 rest of old cycle", hi[0], 54);
        measure(768);
        chk("R8 new setting applied", hi[0], 3 * 192);

        // Random cases.
        for (int k = 0; k < 12; k++) begin
            bit m;
            logic [7:0] d, p;
            m = 1'($urandom);
            d = 8'($urandom);
            p = m ? 8'($urandom % 8) : 8'($urandom);
            run_case(m ? "R4 R5 R6 random blink" : "R2 R3 random dim", m, d, p);
        end

        // R9 R10: per-channel PWM, gate frozen high (reset duty FF, phase 0).
        dim_tick = 1'b0; blink_tick = 1'b0;
        ind_duty = {8'd30, 8'd200, 8'd77, 8'h33};
        out_sel = 8'b10_10_10_11;
        do_reset();
        fast_tick = 1'b1;
        measure(256);
        chk("R9 ch0 gate high", hi[0], 8'h33);
        chk("R9 ch1", hi[1], 77);
        chk("R9 ch2", hi[2], 200);
        chk("R9 ch3", hi[3], 30);

        // R10: load a zero duty into the group, then sel 11 must stay low.
        fast_tick = 1'b0; dim_tick = 1'b1; grp_duty = 8'h00; blink_mode = 1'b0;
        measure(256);
        dim_tick = 1'b0; fast_tick = 1'b1;
        measure(256);
        chk("R10 sel11 gate low", hi[0], 0);
        chk("R10 sel10 unaffected", hi[1], 77);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule